// File: doc/BRIEF.md
# Register Write Coalescing Packer

This block builds a command buffer of register writes in a local 32-bit-wide RAM. A producer hands it requests one at a time over a valid/ready handshake. Each request is one of three kinds: a register write made of a 20-bit offset and a 32-bit value, a finish command, or a clear command. Each instruction the block stores takes an even-aligned pair of dwords. For a single write, the lower dword holds the value and the upper dword holds an opcode, a byte-enable field and the offset.

Two writes may arrive back to back with the same offset. In that case the packer does not append a second pair. It rewrites the earlier instruction in place as an indexed write: the lower dword becomes a running count, the upper dword takes the indexed opcode, and the values follow one after another. A later write to the same offset appends one more value and raises the count. If the values then end on an odd dword, a zero pad dword is added.

The finish command zero-fills the buffer up to the next 64-byte line, so that a fetch engine can be handed a line-aligned tail. The clear command starts a new buffer. The packer tracks its fill level and rejects any write that no longer fits, raising an overflow flag.

Top module: `wcp_packer`

## Requirements
- R1: After reset, tail_bytes is 0, tail_aligned is 1, overflow is 0, req_ready is 1 and buf_we stays low.
- R2: A write (req_op 2'b00) that does not continue the previous instruction first rounds the free pointer up to an even dword A. It then writes the value at A, then 32'h01F0_0000 | offset at A+1. The free pointer becomes A+2.
- R3: A write whose offset equals that of the previous instruction, when that instruction is a single write starting at S, converts it in place. The writes, in this order, are: 2 at S, 32'h0900_0000 | offset at S+1, the old value at S+2 and the new value at S+3. The free pointer becomes S+4.
- R4: A write to the offset of a previous indexed instruction starting at S writes the value at the free pointer F. It then writes the new count at S. If F+1 is odd, it writes 0 at F+1. The free pointer becomes F+1.
- R5: A write whose offset differs from the previous instruction's offset always starts a new instruction, as in R2. So does the first write after a finish or a clear.
- R6: A write that arrives while the free pointer is above DEPTH-2 is dropped with no buffer write and no pointer change. It sets overflow, which stays set until a clear.
- R7: Finish (req_op 2'b01) writes 0 at every dword from the free pointer up to the next multiple of 16, in ascending order, and moves the free pointer there. If the pointer is already a multiple of 16, it writes nothing.
- R8: Clear (req_op 2'b10) sets the free pointer and the instruction start to 0 and clears overflow. The next write is placed at dword 0.
- R9: tail_bytes always equals four times the free pointer, and tail_aligned is 1 exactly when tail_bytes is a multiple of 64.
- R10: The block makes at most one buffer write per cycle. req_ready is low on every cycle that carries a buffer write. req_op 2'b11 is accepted and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 00 write, 01 finish, 10 clear, 11 no-op |
| req_off | input | 20 | Register offset of a write |
| req_val | input | 32 | Register value of a write |
| req_ready | output | 1 | Request accepted on this edge when valid |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | $clog2(DEPTH) | Buffer dword address |
| buf_wdata | output | 32 | Buffer write data |
| tail_bytes | output | $clog2(DEPTH)+3 | Byte offset of the free pointer |
| tail_aligned | output | 1 | Tail sits on a 64-byte line |
| overflow | output | 1 | Sticky: a write was dropped for lack of room |

## Verification
The bench builds the block with DEPTH at its default of 64 dwords, which is only four lines. At that size the pointer walks from 0 through several finish paddings and reaches the capacity limit within a few dozen requests. This makes the drop-and-flag path and the recovery through clear reachable in a short run. The request sequence also makes the free pointer land on an odd dword, on an even dword and exactly on a line boundary, so every padding and alignment branch of the conversion and merge paths is reached.

// File: rtl/wcp_pkg.sv
package wcp_pkg;

  localparam int unsigned OFF_W     = 20;
  localparam int unsigned LINE_BITS = 4;   // 16 dwords = 64 bytes

  localparam logic [7:0] OPC_SINGLE  = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;
  localparam logic [3:0] BYTE_EN_ALL = 4'hF;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'b00,
    OP_FINISH = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_NONE   = 2'b11
  } wcp_op_e;

  typedef enum logic [1:0] {
    PREV_NONE,
    PREV_SINGLE,
    PREV_INDEXED
  } wcp_prev_e;

  typedef enum logic [1:0] {
    ACT_DROP,
    ACT_NEW,
    ACT_CONVERT,
    ACT_MERGE
  } wcp_act_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S_VAL,
    ST_S_HDR,
    ST_C_CNT,
    ST_C_HDR,
    ST_C_OLD,
    ST_C_NEW,
    ST_M_VAL,
    ST_M_CNT,
    ST_M_PAD,
    ST_FILL
  } wcp_state_e;

endpackage

// File: rtl/wcp_classify.sv
module wcp_classify
  import wcp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = 7
) (
  input  logic [PW-1:0]    free_ptr,
  input  wcp_prev_e        prev_kind,
  input  logic [OFF_W-1:0] prev_off,
  input  logic [OFF_W-1:0] new_off,
  output wcp_act_e         act,
  output logic [PW-1:0]    even_base
);

  localparam logic [PW-1:0] ROOM_LIMIT = PW'(DEPTH - 2);

  logic has_room;
  logic same_off;

  always_comb begin
    has_room  = (free_ptr <= ROOM_LIMIT);
    same_off  = (prev_off == new_off);
    even_base = free_ptr + {{(PW-1){1'b0}}, free_ptr[0]};
    if (!has_room)
      act = ACT_DROP;
    else if (same_off && prev_kind == PREV_SINGLE)
      act = ACT_CONVERT;
    else if (same_off && prev_kind == PREV_INDEXED)
      act = ACT_MERGE;
    else
      act = ACT_NEW;
  end

endmodule

// File: rtl/wcp_tailcalc.sv
module wcp_tailcalc
  import wcp_pkg::*;
#(
  parameter int PW = 7
) (
  input  logic [PW-1:0] free_ptr,
  output logic [PW+1:0] tail_bytes,
  output logic          at_line
);

  always_comb begin
    tail_bytes = {free_ptr, 2'b00};
    at_line    = (free_ptr[LINE_BITS-1:0] == '0);
  end

endmodule

// File: rtl/wcp_shadow.sv
module wcp_shadow
  import wcp_pkg::*;
#(
  parameter int PW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_single,
  input  logic             set_indexed,
  input  logic             bump,
  input  logic             forget,
  input  logic             wipe,
  input  logic [PW-1:0]    new_start,
  input  logic [OFF_W-1:0] new_off,
  input  logic [31:0]      new_val,
  output wcp_prev_e        kind,
  output logic [PW-1:0]    start,
  output logic [OFF_W-1:0] off,
  output logic [31:0]      val,
  output logic [PW-1:0]    count
);

  wcp_prev_e        kind_d;
  logic [PW-1:0]    start_d;
  logic [OFF_W-1:0] off_d;
  logic [31:0]      val_d;
  logic [PW-1:0]    count_d;
  logic             en;

  always_comb begin
    kind_d  = kind;
    start_d = start;
    off_d   = off;
    val_d   = val;
    count_d = count;
    en      = set_single | set_indexed | bump | forget | wipe;
    if (wipe) begin
      kind_d  = PREV_NONE;
      start_d = '0;
      count_d = '0;
    end else if (forget) begin
      kind_d  = PREV_NONE;
    end else if (set_single) begin
      kind_d  = PREV_SINGLE;
      start_d = new_start;
      off_d   = new_off;
      val_d   = new_val;
      count_d = PW'(1);
    end else if (set_indexed) begin
      kind_d  = PREV_INDEXED;
      count_d = PW'(2);
    end else if (bump) begin
      count_d = count + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind  <= PREV_NONE;
      start <= '0;
      off   <= '0;
      val   <= '0;
      count <= '0;
    end else if (en) begin
      kind  <= kind_d;
      start <= start_d;
      off   <= off_d;
      val   <= val_d;
      count <= count_d;
    end
  end

endmodule

// File: rtl/wcp_packer.sv
module wcp_packer
  import wcp_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [1:0]                 req_op,
  input  logic [19:0]                req_off,
  input  logic [31:0]                req_val,
  output logic                       req_ready,
  output logic                       buf_we,
  output logic [$clog2(DEPTH)-1:0]   buf_addr,
  output logic [31:0]                buf_wdata,
  output logic [$clog2(DEPTH)+2:0]   tail_bytes,
  output logic                       tail_aligned,
  output logic                       overflow
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // reset released synchronously
  logic [1:0] rst_pipe;
  logic       run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign run = rst_pipe[1];

  wcp_state_e       state_q, state_d;
  logic [PW-1:0]    free_q, free_d;
  logic [OFF_W-1:0] hold_off_q;
  logic [31:0]      hold_val_q;
  logic             hold_en;
  logic             ovf_q, ovf_d;
  logic             accept;
  logic [PW-1:0]    addr_full;

  wcp_act_e         act;
  logic [PW-1:0]    even_base;
  logic             at_line;

  logic             sh_single, sh_indexed, sh_bump, sh_forget, sh_wipe;
  wcp_prev_e        sh_kind;
  logic [PW-1:0]    sh_start;
  logic [OFF_W-1:0] sh_off;
  logic [31:0]      sh_val;
  logic [PW-1:0]    sh_count;

  wcp_classify #(.DEPTH(DEPTH), .PW(PW)) u_classify (
    .free_ptr  (free_q),
    .prev_kind (sh_kind),
    .prev_off  (sh_off),
    .new_off   (req_off),
    .act       (act),
    .even_base (even_base)
  );

  wcp_tailcalc #(.PW(PW)) u_tail (
    .free_ptr   (free_q),
    .tail_bytes (tail_bytes),
    .at_line    (at_line)
  );

  wcp_shadow #(.PW(PW)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_single  (sh_single),
    .set_indexed (sh_indexed),
    .bump        (sh_bump),
    .forget      (sh_forget),
    .wipe        (sh_wipe),
    .new_start   (even_base),
    .new_off     (req_off),
    .new_val     (req_val),
    .kind        (sh_kind),
    .start       (sh_start),
    .off         (sh_off),
    .val         (sh_val),
    .count       (sh_count)
  );

  assign req_ready = run && (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d    = state_q;
    free_d     = free_q;
    ovf_d      = ovf_q;
    hold_en    = 1'b0;
    sh_single  = 1'b0;
    sh_indexed = 1'b0;
    sh_bump    = 1'b0;
    sh_forget  = 1'b0;
    sh_wipe    = 1'b0;
    buf_we     = 1'b0;
    addr_full  = free_q;
    buf_wdata  = '0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          case (wcp_op_e'(req_op))
            OP_WRITE: begin
              hold_en = 1'b1;
              case (act)
                ACT_DROP:    ovf_d = 1'b1;
                ACT_NEW: begin
                  free_d    = even_base;
                  sh_single = 1'b1;
                  state_d   = ST_S_VAL;
                end
                ACT_CONVERT: begin
                  sh_indexed = 1'b1;
                  state_d    = ST_C_CNT;
                end
                default: begin
                  sh_bump = 1'b1;
                  state_d = ST_M_VAL;
                end
              endcase
            end
            OP_FINISH: begin
              sh_forget = 1'b1;
              if (!at_line) state_d = ST_FILL;
            end
            OP_CLEAR: begin
              free_d  = '0;
              ovf_d   = 1'b0;
              sh_wipe = 1'b1;
            end
            default: ;
          endcase
        end
      end
      ST_S_VAL: begin
        buf_we    = 1'b1;
        buf_wdata = hold_val_q;
        free_d    = free_q + PW'(1);
        state_d   = ST_S_HDR;
      end
      ST_S_HDR: begin
        buf_we    = 1'b1;
        buf_wdata = {OPC_SINGLE, BYTE_EN_ALL, hold_off_q};
        free_d    = free_q + PW'(1);
        state_d   = ST_IDLE;
      end
      ST_C_CNT: begin
        buf_we    = 1'b1;
        addr_full = sh_start;
        buf_wdata = {{(32-PW){1'b0}}, sh_count};
        state_d   = ST_C_HDR;
      end
      ST_C_HDR: begin
        buf_we    = 1'b1;
        addr_full = sh_start + PW'(1);
        buf_wdata = {OPC_INDEXED, 4'h0, hold_off_q};
        state_d   = ST_C_OLD;
      end
      ST_C_OLD: begin
        buf_we    = 1'b1;
        buf_wdata = sh_val;
        free_d    = free_q + PW'(1);
        state_d   = ST_C_NEW;
      end
      ST_C_NEW: begin
        buf_we    = 1'b1;
        buf_wdata = hold_val_q;
        free_d    = free_q + PW'(1);
        state_d   = ST_IDLE;
      end
      ST_M_VAL: begin
        buf_we    = 1'b1;
        buf_wdata = hold_val_q;
        free_d    = free_q + PW'(1);
        state_d   = ST_M_CNT;
      end
      ST_M_CNT: begin
        buf_we    = 1'b1;
        addr_full = sh_start;
        buf_wdata = {{(32-PW){1'b0}}, sh_count};
        state_d   = free_q[0] ? ST_M_PAD : ST_IDLE;
      end
      ST_M_PAD: begin
        buf_we    = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_FILL: begin
        buf_we  = 1'b1;
        free_d  = free_q + PW'(1);
        if (free_d[LINE_BITS-1:0] == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign buf_addr = addr_full[AW-1:0];
  logic unused_addr_msb;
  assign unused_addr_msb = addr_full[AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      free_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      free_q  <= free_d;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_off_q <= '0;
      hold_val_q <= '0;
    end else if (hold_en) begin
      hold_off_q <= req_off;
      hold_val_q <= req_val;
    end
  end

  assign tail_aligned = at_line;
  assign overflow     = ovf_q;

endmodule

// File: rtl/wcp_packer_chk.sv
module wcp_packer_chk #(
  parameter int DEPTH = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [1:0]               req_op,
  input logic                     req_ready,
  input logic                     buf_we,
  input logic [$clog2(DEPTH)+2:0] tail_bytes,
  input logic                     overflow
);

  logic acc;
  assign acc = req_valid && req_ready;

  AST_WRITE_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !req_ready); // R10

  AST_NOOP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b11) |=> ($stable(tail_bytes) && req_ready && !buf_we)); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(acc && req_op == 2'b10)) |=> overflow); // R6

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b00 && tail_bytes > (DEPTH - 2) * 4)
      |=> (overflow && $stable(tail_bytes) && !buf_we)); // R6

  AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tail_bytes <= DEPTH * 4); // R6

  AST_CLEAR_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'b10) |=> (tail_bytes == 0 && !overflow)); // R8

  AST_IDLE_TAIL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(tail_bytes)); // R9

endmodule

bind wcp_packer wcp_packer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_ready  (req_ready),
  .buf_we     (buf_we),
  .tail_bytes (tail_bytes),
  .overflow   (overflow)
);

// File: tb/wcp_packer_test.sv
`timescale 1ns/1ps
module wcp_packer_test;

  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [19:0]       req_off;
  logic [31:0]       req_val;
  logic              req_ready;
  logic              buf_we;
  logic [AW-1:0]     buf_addr;
  logic [31:0]       buf_wdata;
  logic [AW+2:0]     tail_bytes;
  logic              tail_aligned;
  logic              overflow;

  always #2.5 clk = ~clk;

  wcp_packer #(.DEPTH(DEPTH)) uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_op (req_op), .req_off (req_off), .req_val (req_val),
    .req_ready (req_ready),
    .buf_we (buf_we), .buf_addr (buf_addr), .buf_wdata (buf_wdata),
    .tail_bytes (tail_bytes), .tail_aligned (tail_aligned), .overflow (overflow)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // scoreboard of expected buffer writes: {tag, addr, data}
  typedef struct { string tag; int addr; logic [31:0] data; } exp_t;
  exp_t q[$];

  // reference state
  int          m_free, m_start, m_kind, m_cnt;  // kind 0 none, 1 single, 2 indexed
  logic [19:0] m_off;
  logic [31:0] m_val;
  bit          m_ovf;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input int a, input logic [31:0] d);
    exp_t e;
    e.tag = tag; e.addr = a; e.data = d;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && buf_we === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected write addr", longint'(buf_addr), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(buf_addr) == e.addr, {e.tag, " addr"}, longint'(buf_addr), longint'(e.addr));
        check(buf_wdata == e.data, {e.tag, " data"}, longint'(buf_wdata), longint'(e.data));
      end
      check(req_ready == 1'b0, "R10 ready during write", longint'(req_ready), 0);
    end
  end

  task automatic issue(input logic [1:0] op, input logic [19:0] off, input logic [31:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_off = off; req_val = val;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    check(int'(tail_bytes) == m_free * 4, {tag, " tail_bytes"}, longint'(tail_bytes), longint'(m_free * 4));
    check(tail_aligned == ((m_free % 16) == 0), {"R9 ", tag, " tail_aligned"},
          longint'(tail_aligned), longint'((m_free % 16) == 0));
    check(overflow == m_ovf, {tag, " overflow"}, longint'(overflow), longint'(m_ovf));
  endtask

  task automatic do_write(input string tag, input logic [19:0] off, input logic [31:0] val);
    if (m_free > DEPTH - 2) begin
      m_ovf = 1'b1;
    end else if (m_kind == 1 && off == m_off) begin
      push({tag, " conv cnt"}, m_start, 32'd2);
      push({tag, " conv hdr"}, m_start + 1, 32'h0900_0000 | 32'(off));
      push({tag, " conv old"}, m_start + 2, m_val);
      push({tag, " conv new"}, m_start + 3, val);
      m_free = m_start + 4; m_kind = 2; m_cnt = 2;
    end else if (m_kind == 2 && off == m_off) begin
      push({tag, " merge val"}, m_free, val);
      m_free++; m_cnt++;
      push({tag, " merge cnt"}, m_start, 32'(m_cnt));
      if (m_free % 2 == 1) push({tag, " merge pad"}, m_free, 32'd0);
    end else begin
      int b;
      b = m_free + (m_free % 2);
      push({tag, " single val"}, b, val);
      push({tag, " single hdr"}, b + 1, 32'h01F0_0000 | 32'(off));
      m_start = b; m_free = b + 2; m_kind = 1; m_off = off; m_val = val;
    end
    issue(2'b00, off, val);
    check_state(tag);
  endtask

  task automatic do_finish(input string tag);
    while (m_free % 16 != 0) begin
      push({tag, " fill"}, m_free, 32'd0);
      m_free++;
    end
    m_kind = 0;
    issue(2'b01, 20'h0, 32'h0);
    check_state(tag);
  endtask

  task automatic do_clear(input string tag);
    m_free = 0; m_start = 0; m_kind = 0; m_cnt = 0; m_ovf = 1'b0;
    issue(2'b10, 20'h0, 32'h0);
    check_state(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    req_valid = 1'b0; req_op = 2'b00; req_off = '0; req_val = '0;
    m_free = 0; m_start = 0; m_kind = 0; m_cnt = 0; m_off = '0; m_val = '0; m_ovf = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(tail_bytes == 0, "R1 tail_bytes", longint'(tail_bytes), 0);
    check(tail_aligned == 1'b1, "R1 tail_aligned", longint'(tail_aligned), 1);
    check(overflow == 1'b0, "R1 overflow", longint'(overflow), 0);
    check(req_ready == 1'b1, "R1 req_ready", longint'(req_ready), 1);

    do_write("R2 first", 20'h00100, 32'hA000_0001);
    do_write("R3 convert", 20'h00100, 32'hA000_0002);
    do_write("R4 merge odd", 20'h00100, 32'hA000_0003);   // pad at 5
    do_write("R4 merge even", 20'h00100, 32'hA000_0004);  // no pad
    do_write("R2 after merge", 20'h00204, 32'hB000_0001);
    do_write("R5 other off", 20'h00308, 32'hC000_0001);
    do_write("R5 back to earlier", 20'h00204, 32'hB000_0002);
    do_write("R2 base", 20'h0040C, 32'hD000_0001);
    do_write("R3 to line", 20'h0040C, 32'hD000_0002);     // free 16
    do_write("R4 past line", 20'h0040C, 32'hD000_0003);   // free 17, pad
    do_write("R2 odd align", 20'h00510, 32'hE000_0001);   // aligns 17 -> 18
    do_finish("R7 fill");                                 // to 32
    do_write("R5 after finish", 20'h00510, 32'hE000_0002);
    do_finish("R7 fill again");                           // to 48
    do_finish("R7 aligned noop");

    // R10 no-op opcode
    issue(2'b11, 20'h00510, 32'hFFFF_FFFF);
    check_state("R10 noop");

    for (int i = 0; i < 8; i++)
      do_write("R6 fill up", 20'(20'h01000 + i * 4), 32'(32'h7000_0000 + i));
    do_write("R6 drop", 20'h02000, 32'h6666_6666);
    do_write("R6 drop same off", 20'h0101C, 32'h6666_6667);
    do_finish("R6 finish at end");

    do_clear("R8 clear");
    do_write("R8 restart", 20'h00ABC, 32'h1234_5678);
    do_write("R8 convert", 20'h00ABC, 32'h1234_5679);
    do_clear("R8 clear again");

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R10 pending writes", longint'(q.size()), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule